// File: doc/BRIEF.md
# External Memory Bus Cycle Stretcher

This block runs one read or one write at a time on an external data-memory bus. The bus carries the low address byte and the data on the same eight wires. A separate port carries the high address byte. An address latch strobe (ALE) tells the memory when to capture the low address byte. Active-low read and write strobes then carry out the data transfer. The core side presents a request with a 16-bit address, a direction bit and write data. The block returns the read data and a one-clock completion pulse.

Slow memories need more time than the fastest bus timing allows, so two cycle counts are programmable. The first sets how long the low address byte is held stable before and after the falling edge of ALE. The second sets how long the read or write strobe stays low. Both counts live in one control register, which is reached through a byte-wide special-function-register port. A copy of both counts is taken when a request is accepted, so a register write made during a bus cycle only affects later cycles.

Top module: `ext_bus_stretcher`

## Requirements
- R1: After reset, the control register reads 0x23. ALE is low, both strobes are high, `reqReady` is high and `done` is low.
- R2: The control register is at SFR address 0x8F.
  - Bits 5:4 hold the address stretch field A.
  - Bits 2:0 hold the strobe stretch field W.
  - Bits 7, 6 and 3 read as 0 and ignore writes.
  - A read from any other SFR address returns 0, and a write to any other address leaves the register unchanged.
- R3: A request is accepted on a clock edge. After that edge, ALE stays high for A+1 cycles, with the low address byte driven on `busOut` (`busOe` high).
- R4: After ALE falls, the low address byte stays driven for a further A+1 cycles. Both strobes stay high during this phase and during the ALE-high phase.
- R5: The strobe then stays low for W+1 cycles. For a write this is `wrN`; for a read it is `rdN`.
- R6: During a write strobe, the write data is driven on `busOut` with `busOe` high. During a read strobe, `busOe` is low. The value on `busIn` in the last strobe cycle is returned on `rdData`.
- R7: `done` goes high for exactly one cycle, in the cycle right after the strobe is released. `rdData` holds the read value from that cycle onwards.
- R8: The high address byte of the accepted request stays on `busAddrHi` for the whole bus cycle.
- R9: `reqReady` is high only when no bus cycle is in progress. A request raised while busy is ignored; it starts no extra bus cycle and does not disturb the current one.
- R10: A register write made during a bus cycle does not change that cycle's timing. The next cycle uses the new values.
- R11: `rdN` and `wrN` are never low in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sfrAddr | input | 8 | SFR address |
| sfrWe | input | 1 | SFR write enable |
| sfrWdata | input | 8 | SFR write data |
| sfrRdata | output | 8 | SFR read data (combinational) |
| reqValid | input | 1 | Request a bus cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 16 | Request address |
| reqWdata | input | 8 | Request write data |
| reqReady | output | 1 | Idle; a request is accepted this cycle |
| rdData | output | 8 | Captured read data |
| done | output | 1 | One-cycle completion pulse |
| busAddrHi | output | 8 | High address byte |
| busOut | output | 8 | Multiplexed bus output value |
| busOe | output | 1 | Output enable for the multiplexed bus |
| busIn | input | 8 | Multiplexed bus input value |
| ale | output | 1 | Address latch enable |
| rdN | output | 1 | Read strobe, active low |
| wrN | output | 1 | Write strobe, active low |

## Verification
The bench builds the block with its default parameters:
- a 16-bit address and an 8-bit data path;
- a 2-bit address stretch field at bit 4;
- a 3-bit strobe stretch field at bit 0;
- the register at 0x8F with reset value 0x23.

With these values the bench can reach both ends of each field: A of 0 and 3, and W of 0 and 7. It also runs the mixed reset setting and a mid-cycle change between two unequal settings.

During a read, `busIn` is fed a different value in every strobe cycle except the last. A capture made one cycle early or late therefore shows up as wrong `rdData`.

// File: rtl/xbs_pkg.sv
`timescale 1ns/1ps
package xbs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_HOLD,
    ST_STROBE,
    ST_DONE
  } xbsState_e;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic takeReq;     // latch request, snapshot fields, load setup count
    logic loadHold;    // reload counter with address stretch
    logic loadStrobe;  // reload counter with strobe stretch
    logic captureRd;   // sample the input bus into the read register
    logic countDown;   // decrement the phase counter
  } xbsCtl_t;

endpackage

// File: rtl/xbs_datapath.sv
`timescale 1ns/1ps
module xbs_datapath
  import xbs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int SFR_AW = 8,
  parameter logic [SFR_AW-1:0] SFR_ADDR = 8'h8F,
  parameter logic [DATA_W-1:0] RESET_VAL = 8'h23,
  parameter int ALE_W = 2,
  parameter int ALE_LSB = 4,
  parameter int RW_W = 3,
  parameter int RW_LSB = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  xbsCtl_t           ctl,
  input  logic [SFR_AW-1:0] sfrAddr,
  input  logic              sfrWe,
  input  logic [DATA_W-1:0] sfrWdata,
  output logic [DATA_W-1:0] sfrRdata,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] busIn,
  output logic [ADDR_W-DATA_W-1:0] busAddrHi,
  output logic [DATA_W-1:0] addrLo,
  output logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              isWrite,
  output logic              cntZero
);

  localparam int CNT_W = (ALE_W > RW_W) ? ALE_W : RW_W;
  localparam int HI_W  = ADDR_W - DATA_W;

  // Control register fields
  logic [ALE_W-1:0] aleFld;
  logic [RW_W-1:0]  rwFld;
  logic             sfrHit;
  logic             unusedSfrBits;

  assign sfrHit = (sfrAddr == SFR_ADDR);
  assign unusedSfrBits = ^sfrWdata;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aleFld <= RESET_VAL[ALE_LSB +: ALE_W];
      rwFld  <= RESET_VAL[RW_LSB +: RW_W];
    end else if (sfrWe && sfrHit) begin
      aleFld <= sfrWdata[ALE_LSB +: ALE_W];
      rwFld  <= sfrWdata[RW_LSB +: RW_W];
    end
  end

  always_comb begin
    sfrRdata = '0;
    if (sfrHit) begin
      sfrRdata[ALE_LSB +: ALE_W] = aleFld;
      sfrRdata[RW_LSB +: RW_W]   = rwFld;
    end
  end

  // Request capture and per-cycle snapshot of the stretch settings
  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] dataReg;
  logic              dirReg;
  logic [ALE_W-1:0]  aleSnap;
  logic [RW_W-1:0]   rwSnap;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
      dataReg <= '0;
      dirReg  <= 1'b0;
      aleSnap <= '0;
      rwSnap  <= '0;
    end else if (ctl.takeReq) begin
      addrReg <= reqAddr;
      dataReg <= reqWdata;
      dirReg  <= reqWrite;
      aleSnap <= aleFld;
      rwSnap  <= rwFld;
    end
  end

  // Phase counter
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (ctl.takeReq) begin
      cnt <= CNT_W'(aleFld);
    end else if (ctl.loadHold) begin
      cnt <= CNT_W'(aleSnap);
    end else if (ctl.loadStrobe) begin
      cnt <= CNT_W'(rwSnap);
    end else if (ctl.countDown) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  assign cntZero = (cnt == '0);

  // Read capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (ctl.captureRd && !dirReg) begin
      rdData <= busIn;
    end
  end

  assign busAddrHi = addrReg[ADDR_W-1 -: HI_W];
  assign addrLo    = addrReg[DATA_W-1:0];
  assign wrData    = dataReg;
  assign isWrite   = dirReg;

endmodule

// File: rtl/xbs_control.sv
`timescale 1ns/1ps
module xbs_control
  import xbs_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    isWrite,
  input  logic    cntZero,
  output xbsCtl_t ctl,
  output logic    ale,
  output logic    rdN,
  output logic    wrN,
  output logic    busOe,
  output logic    selData,
  output logic    reqReady,
  output logic    done
);

  xbsState_e state;
  xbsState_e stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt = state;
    ctl      = '0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          ctl.takeReq = 1'b1;
          stateNxt    = ST_SETUP;
        end
      end
      ST_SETUP: begin
        if (cntZero) begin
          ctl.loadHold = 1'b1;
          stateNxt     = ST_HOLD;
        end else begin
          ctl.countDown = 1'b1;
        end
      end
      ST_HOLD: begin
        if (cntZero) begin
          ctl.loadStrobe = 1'b1;
          stateNxt       = ST_STROBE;
        end else begin
          ctl.countDown = 1'b1;
        end
      end
      ST_STROBE: begin
        if (cntZero) begin
          ctl.captureRd = 1'b1;
          stateNxt      = ST_DONE;
        end else begin
          ctl.countDown = 1'b1;
        end
      end
      ST_DONE: stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  logic addrPhase;
  logic strobePhase;

  assign addrPhase   = (state == ST_SETUP) || (state == ST_HOLD);
  assign strobePhase = (state == ST_STROBE);
  assign ale         = (state == ST_SETUP);
  assign rdN         = !(strobePhase && !isWrite);
  assign wrN         = !(strobePhase && isWrite);
  assign busOe       = addrPhase || (strobePhase && isWrite);
  assign selData     = strobePhase;
  assign reqReady    = (state == ST_IDLE);
  assign done        = (state == ST_DONE);

endmodule

// File: rtl/ext_bus_stretcher.sv
`timescale 1ns/1ps
module ext_bus_stretcher
  import xbs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int SFR_AW = 8,
  parameter logic [SFR_AW-1:0] SFR_ADDR = 8'h8F,
  parameter logic [DATA_W-1:0] RESET_VAL = 8'h23,
  parameter int ALE_W = 2,
  parameter int ALE_LSB = 4,
  parameter int RW_W = 3,
  parameter int RW_LSB = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [SFR_AW-1:0] sfrAddr,
  input  logic              sfrWe,
  input  logic [DATA_W-1:0] sfrWdata,
  output logic [DATA_W-1:0] sfrRdata,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              reqReady,
  output logic [DATA_W-1:0] rdData,
  output logic              done,
  output logic [ADDR_W-DATA_W-1:0] busAddrHi,
  output logic [DATA_W-1:0] busOut,
  output logic              busOe,
  input  logic [DATA_W-1:0] busIn,
  output logic              ale,
  output logic              rdN,
  output logic              wrN
);

  xbsCtl_t           ctl;
  logic              isWrite;
  logic              cntZero;
  logic              selData;
  logic [DATA_W-1:0] addrLo;
  logic [DATA_W-1:0] wrData;

  xbs_control u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .isWrite  (isWrite),
    .cntZero  (cntZero),
    .ctl      (ctl),
    .ale      (ale),
    .rdN      (rdN),
    .wrN      (wrN),
    .busOe    (busOe),
    .selData  (selData),
    .reqReady (reqReady),
    .done     (done)
  );

  xbs_datapath #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .SFR_AW    (SFR_AW),
    .SFR_ADDR  (SFR_ADDR),
    .RESET_VAL (RESET_VAL),
    .ALE_W     (ALE_W),
    .ALE_LSB   (ALE_LSB),
    .RW_W      (RW_W),
    .RW_LSB    (RW_LSB)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .sfrAddr   (sfrAddr),
    .sfrWe     (sfrWe),
    .sfrWdata  (sfrWdata),
    .sfrRdata  (sfrRdata),
    .reqWrite  (reqWrite),
    .reqAddr   (reqAddr),
    .reqWdata  (reqWdata),
    .busIn     (busIn),
    .busAddrHi (busAddrHi),
    .addrLo    (addrLo),
    .wrData    (wrData),
    .rdData    (rdData),
    .isWrite   (isWrite),
    .cntZero   (cntZero)
  );

  assign busOut = selData ? wrData : addrLo;

endmodule

// File: rtl/xbs_checker.sv
`timescale 1ns/1ps
module xbs_checker #(
  parameter int HI_W = 8,
  parameter int RW_W = 3
) (
  input logic            clk,
  input logic            rstN,
  input logic            ale,
  input logic            rdN,
  input logic            wrN,
  input logic            busOe,
  input logic            done,
  input logic            reqReady,
  input logic [HI_W-1:0] busAddrHi
);

  localparam int MAX_STROBE = 1 << RW_W;

  // Length of the current strobe-low run
  int strobeRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             strobeRun <= 0;
    else if (!rdN || !wrN) strobeRun <= strobeRun + 1;
    else                   strobeRun <= 0;
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(!rdN && !wrN));  // R11
  AST_NO_ALE_IN_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    (!rdN || !wrN) |-> !ale);  // R4
  AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (!rstN)
    !wrN |-> busOe);  // R6
  AST_READ_FLOATS: assert property (@(posedge clk) disable iff (!rstN)
    !rdN |-> !busOe);  // R6
  AST_DONE_ONE_CLK: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);  // R7
  AST_DONE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(!rdN || !wrN));  // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (!ale && rdN && wrN && !done));  // R9
  AST_HI_BYTE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!reqReady && $past(!reqReady)) |-> $stable(busAddrHi));  // R8
  AST_STROBE_MAX: assert property (@(posedge clk) disable iff (!rstN)
    strobeRun <= MAX_STROBE);  // R5

endmodule

bind ext_bus_stretcher xbs_checker #(
  .HI_W (ADDR_W - DATA_W),
  .RW_W (RW_W)
) u_xbs_chk (
  .clk       (clk),
  .rstN      (rstN),
  .ale       (ale),
  .rdN       (rdN),
  .wrN       (wrN),
  .busOe     (busOe),
  .done      (done),
  .reqReady  (reqReady),
  .busAddrHi (busAddrHi)
);

// File: tb/ext_bus_stretcher_test.sv
`timescale 1ns/1ps
module ext_bus_stretcher_test;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rstN;
  logic [7:0]  sfrAddr;
  logic        sfrWe;
  logic [7:0]  sfrWdata;
  logic [7:0]  sfrRdata;
  logic        reqValid;
  logic        reqWrite;
  logic [15:0] reqAddr;
  logic [7:0]  reqWdata;
  logic        reqReady;
  logic [7:0]  rdData;
  logic        done;
  logic [7:0]  busAddrHi;
  logic [7:0]  busOut;
  logic        busOe;
  logic [7:0]  busIn;
  logic        ale;
  logic        rdN;
  logic        wrN;

  ext_bus_stretcher uut (
    .clk(clk), .rstN(rstN),
    .sfrAddr(sfrAddr), .sfrWe(sfrWe), .sfrWdata(sfrWdata), .sfrRdata(sfrRdata),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .reqReady(reqReady), .rdData(rdData), .done(done),
    .busAddrHi(busAddrHi), .busOut(busOut), .busOe(busOe), .busIn(busIn),
    .ale(ale), .rdN(rdN), .wrN(wrN)
  );

  typedef struct {
    bit          wr;
    logic [15:0] addr;
    logic [7:0]  data;
    int          aCyc;
    int          wCyc;
  } item_t;

  item_t q[$];
  int nChecks = 0;
  int nFail = 0;

  function automatic logic [7:0] memVal(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic sfrWrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    sfrAddr = a; sfrWdata = d; sfrWe = 1'b1;
    @(negedge clk);
    sfrWe = 1'b0;
  endtask

  task automatic sfrCheck(input logic [7:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    sfrAddr = a;
    #0.5;
    chk(sfrRdata == exp, tag, sfrRdata, exp);
  endtask

  // Driver: queue expected bus cycle, raise request, wait for completion
  task automatic runTxn(input bit wr, input logic [15:0] a, input logic [7:0] d,
                        input int aCyc, input int wCyc);
    item_t it;
    it.wr = wr; it.addr = a; it.data = d; it.aCyc = aCyc; it.wCyc = wCyc;
    q.push_back(it);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    @(negedge clk);
    reqValid = 1'b0;
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  // Monitor: pops expected cycles and checks the bus waveform
  initial begin
    item_t it;
    int n;
    busIn = 8'hC3;
    forever begin
      @(negedge clk);
      if (rstN && ale) begin
        if (q.size() == 0) begin
          chk(1'b0, "R9 unexpected bus cycle", 1, 0);
        end else begin
          it = q.pop_front();
          n = 0;
          while (ale && n < 20) begin
            chk(busOe && busOut == it.addr[7:0] && rdN && wrN,
                "R3 address with ALE high", busOut, it.addr[7:0]);
            chk(busAddrHi == it.addr[15:8], "R8 high byte", busAddrHi, it.addr[15:8]);
            n++;
            @(negedge clk);
          end
          chk(n == it.aCyc, "R3 ALE high length", n, it.aCyc);
          n = 0;
          while (rdN && wrN && !done && n < 20) begin
            chk(busOe && busOut == it.addr[7:0] && !ale,
                "R4 address hold after ALE", busOut, it.addr[7:0]);
            n++;
            @(negedge clk);
          end
          chk(n == it.aCyc, "R4 hold length", n, it.aCyc);
          n = 0;
          while ((!rdN || !wrN) && n < 20) begin
            chk(!(!rdN && !wrN), "R11 strobes exclusive", {rdN, wrN}, 2'b01);
            chk(it.wr ? !wrN : !rdN, "R5 strobe direction", {rdN, wrN}, it.wr ? 2'b10 : 2'b01);
            chk(busAddrHi == it.addr[15:8], "R8 high byte in strobe", busAddrHi, it.addr[15:8]);
            if (it.wr) begin
              chk(busOe && busOut == it.data, "R6 write data on bus", busOut, it.data);
            end else begin
              chk(!busOe, "R6 bus released on read", busOe, 0);
              busIn = (n == it.wCyc - 1) ? memVal(it.addr) : (8'h5A ^ 8'(n));
            end
            n++;
            @(negedge clk);
          end
          chk(n == it.wCyc, "R5 strobe length", n, it.wCyc);
          busIn = 8'hC3;
          chk(done, "R7 done after strobe release", done, 1);
          if (!it.wr) chk(rdData == memVal(it.addr), "R6 read data last strobe clock",
                          rdData, memVal(it.addr));
          @(negedge clk);
          chk(!done, "R7 done lasts one clock", done, 0);
          chk(reqReady, "R9 ready after cycle", reqReady, 1);
          if (!it.wr) chk(rdData == memVal(it.addr), "R7 read data held",
                          rdData, memVal(it.addr));
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    rstN = 1'b0; sfrAddr = 8'h00; sfrWe = 1'b0; sfrWdata = 8'h00;
    reqValid = 1'b0; reqWrite = 1'b0; reqAddr = 16'h0; reqWdata = 8'h0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!ale && rdN && wrN, "R1 bus idle after reset", {ale, rdN, wrN}, 3'b011);
    chk(reqReady && !done, "R1 ready, no done", {reqReady, done}, 2'b10);
    sfrCheck(8'h8F, 8'h23, "R1 register reset value");

    // Reset setting: A=2, W=3
    runTxn(1'b1, 16'h12A5, 8'h7E, 3, 4);
    runTxn(1'b0, 16'h4C33, 8'h00, 3, 4);

    // R2 field masking and address decode
    sfrWrite(8'h8F, 8'hFF);
    sfrCheck(8'h8F, 8'h37, "R2 unused bits read zero");
    sfrWrite(8'h8E, 8'h00);
    sfrCheck(8'h8F, 8'h37, "R2 other address does not write");
    sfrCheck(8'h8E, 8'h00, "R2 other address reads zero");

    // Maximum stretch A=3, W=7
    runTxn(1'b1, 16'hA55A, 8'hC9, 4, 8);
    runTxn(1'b0, 16'hFF01, 8'h00, 4, 8);

    // Minimum stretch A=0, W=0
    sfrWrite(8'h8F, 8'h00);
    sfrCheck(8'h8F, 8'h00, "R2 zero setting");
    runTxn(1'b0, 16'h0180, 8'h00, 1, 1);
    runTxn(1'b1, 16'hE00F, 8'h3B, 1, 1);

    // R10 mid-cycle register change: A=1,W=5 then A=3,W=2
    sfrWrite(8'h8F, 8'h15);
    fork
      runTxn(1'b1, 16'h5EED, 8'h99, 2, 6);
      begin
        repeat (3) @(negedge clk);
        sfrAddr = 8'h8F; sfrWdata = 8'h32; sfrWe = 1'b1;
        @(negedge clk);
        sfrWe = 1'b0;
      end
    join
    sfrCheck(8'h8F, 8'h32, "R10 register updated mid-cycle");
    runTxn(1'b0, 16'h6B10, 8'h00, 4, 3);  // R10 next cycle uses new values

    // R9 request while busy is ignored
    sfrWrite(8'h8F, 8'h37);
    fork
      runTxn(1'b1, 16'h2468, 8'h51, 4, 8);
      begin
        repeat (4) @(negedge clk);
        reqValid = 1'b1; reqWrite = 1'b0; reqAddr = 16'hDEAD;
        chk(!reqReady, "R9 not ready while busy", reqReady, 0);
        repeat (3) @(negedge clk);
        reqValid = 1'b0;
      end
    join
    repeat (30) @(negedge clk);
    chk(reqReady && q.size() == 0, "R9 no extra cycle", q.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule